// File: doc/BRIEF.md
# Branch-Capable Instruction Fetch Unit

This block is the front end of a single-cycle processor. It keeps the program counter, reads the instruction word held at that address in its own word-organised instruction store, and decides the next program counter on every rising clock edge. The instruction word and the current program counter are presented combinationally to the decoder and datapath within the same cycle.

Control supplies a branch request and the datapath supplies a register-equality flag. The next address is the sequential address (current plus four) unless both are high, in which case the 16-bit offset carried in the low half of the current instruction is sign-extended, multiplied by four and added to the sequential address. A write port lets the environment fill the instruction store before execution begins; writes are accepted in reset as well.

Top module: `fetch_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter becomes 0 at that edge, whatever the branch inputs are; it does not change between edges.
- R2: `instr` always equals the store word whose index is `pc[IDX_W+1:2]`, in the same cycle that `pc` takes its value.
- R3: When `br_sel` is 0, the next program counter is the current one plus 4, whatever `regs_equal` is.
- R4: When `br_sel` is 1 and `regs_equal` is 0, the next program counter is the current one plus 4.
- R5: When `br_sel` and `regs_equal` are both 1, the next program counter is the current one plus 4 plus the sign-extended `instr[15:0]` shifted left by two bits (a zero offset gives plus 4).
- R6: An offset with bit 15 set branches backward, so a loop can return to an earlier word; the most negative offset 16'h8000 subtracts 131072 modulo 2^32.
- R7: Bits 1:0 of `pc` are 0 in every cycle after reset.
- R8: A rising edge with `imem_we` high stores `imem_wdata` at index `imem_waddr`; the new word is visible on `instr` only after that edge, and writes are taken during reset.
- R9: An address beyond the store's size reads the word selected by its low index bits, i.e. the store repeats across the 32-bit address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| br_sel | input | 1 | Branch request from control |
| regs_equal | input | 1 | Register-equality flag from the datapath |
| imem_we | input | 1 | Store write enable |
| imem_waddr | input | IDX_W | Store word index to write |
| imem_wdata | input | 32 | Store word to write |
| instr | output | 32 | Instruction at the current program counter |
| pc | output | PC_W | Current program counter |

## Verification
The bound checker watches, on every cycle, that reset forces the counter to zero, that the counter stays word-aligned, and that each step is either plus four or the offset-adjusted target depending on the two branch inputs. What the checker cannot see is whether the right word comes out of the store: the bench's program, with a distinct tag in every word, shows correct indexing, the backward loop, wrap-around of large addresses and the write timing relative to the clock edge.

// File: rtl/fetch_pkg.sv
// Package: shared constants and helpers for the fetch unit.
// Assumes a fixed 32-bit instruction with the branch offset in bits 15:0.
package fetch_pkg;

    localparam int INSTR_W  = 32;
    localparam int OFFSET_W = 16;
    localparam int STEP     = 4;

    typedef logic [INSTR_W-1:0] instr_t;

endpackage

// File: rtl/fetch_pc_reg.sv
// Module: program counter register.
// Holds the current fetch address; synchronous active-low reset to zero.
// Assumes the next value is already word aligned.
module fetch_pc_reg #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pc_next,
    output logic [PC_W-1:0] pc_q
);

    // Capture the next address each edge, or clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

endmodule

// File: rtl/fetch_next_pc.sv
// Module: next-address logic.
// Forms PC+4 and, when a branch is requested and the equality flag holds,
// adds the sign-extended offset scaled by four. Arithmetic wraps modulo 2^PC_W.
module fetch_next_pc
    import fetch_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic                pc_branch_req,
    input  logic                pc_cond_eq,
    input  logic [PC_W-1:0]     pc_cur,
    input  logic [OFFSET_W-1:0] pc_offset,
    output logic [PC_W-1:0]     pc_next
);

    localparam int EXT_W = PC_W - OFFSET_W - 2;

    logic            take;
    logic [PC_W-1:0] seq_addr;
    logic [PC_W-1:0] disp;

    // Effective branch decision: request qualified by the condition.
    always_comb take = pc_branch_req & pc_cond_eq;

    // Sequential address and scaled, sign-extended displacement.
    always_comb begin
        seq_addr = pc_cur + PC_W'(STEP);
        disp     = {{EXT_W{pc_offset[OFFSET_W-1]}}, pc_offset, 2'b00};
    end

    // Select the address for the next cycle.
    always_comb pc_next = take ? (seq_addr + disp) : seq_addr;

endmodule

// File: rtl/fetch_imem.sv
// Module: instruction store.
// Word array with one synchronous write port and one combinational read port.
// Contents are not reset; the environment fills them before use.
module fetch_imem
    import fetch_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  instr_t           wr_word,
    input  logic [IDX_W-1:0] rd_idx,
    output instr_t           rd_word
);

    instr_t words [DEPTH];

    // Store a word on the write port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_idx] <= wr_word;
        end
    end

    // Read the addressed word without a clock.
    always_comb rd_word = words[rd_idx];

endmodule

// File: rtl/fetch_unit.sv
// Module: top of the instruction fetch unit.
// Ties together the PC register, the next-address logic and the store.
// The store is indexed by pc[IDX_W+1:2]; higher PC bits are ignored (repeat).
module fetch_unit
    import fetch_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int IMEM_DEPTH = 64,
    localparam int IDX_W     = $clog2(IMEM_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_sel,
    input  logic             regs_equal,
    input  logic             imem_we,
    input  logic [IDX_W-1:0] imem_waddr,
    input  logic [31:0]      imem_wdata,
    output logic [31:0]      instr,
    output logic [PC_W-1:0]  pc
);

    logic [PC_W-1:0]  pc_nxt;
    logic [IDX_W-1:0] rd_idx;

    // Word index from the byte address.
    always_comb rd_idx = pc[IDX_W+1:2];

    fetch_pc_reg #(.PC_W(PC_W)) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .pc_next (pc_nxt),
        .pc_q    (pc)
    );

    fetch_imem #(.DEPTH(IMEM_DEPTH)) u_imem (
        .clk     (clk),
        .wr_en   (imem_we),
        .wr_idx  (imem_waddr),
        .wr_word (imem_wdata),
        .rd_idx  (rd_idx),
        .rd_word (instr)
    );

    fetch_next_pc #(.PC_W(PC_W)) u_npc (
        .pc_branch_req (br_sel),
        .pc_cond_eq    (regs_equal),
        .pc_cur        (pc),
        .pc_offset     (instr[OFFSET_W-1:0]),
        .pc_next       (pc_nxt)
    );

endmodule

// File: rtl/fetch_unit_chk.sv
// Module: assertion checker for the fetch unit, attached by bind.
// Observes ports only.
module fetch_unit_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            br_sel,
    input logic            regs_equal,
    input logic [31:0]     instr,
    input logic [PC_W-1:0] pc
);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> pc == '0);

    // R7
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00);

    // R3
    no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !br_sel |=> pc == $past(pc) + PC_W'(4));

    // R4
    not_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_sel && !regs_equal) |=> pc == $past(pc) + PC_W'(4));

    // R5
    taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_sel && regs_equal) |=> pc == $past(pc) + PC_W'(4)
            + {{(PC_W-18){$past(instr[15])}}, $past(instr[15:0]), 2'b00});

    // R6
    backward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_sel && regs_equal && instr[15] && instr[15:2] != 14'h0)
            |=> pc != $past(pc) + PC_W'(4));

endmodule

bind fetch_unit fetch_unit_chk #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_sel     (br_sel),
    .regs_equal (regs_equal),
    .instr      (instr),
    .pc         (pc)
);

// File: tb/test_fetch_unit.sv
module test_fetch_unit;

    localparam int DEPTH = 64;
    localparam int IW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          br_sel = 1'b0;
    logic          regs_equal = 1'b0;
    logic          imem_we = 1'b0;
    logic [IW-1:0] imem_waddr = '0;
    logic [31:0]   imem_wdata = '0;
    logic [31:0]   instr;
    logic [31:0]   pc;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    fetch_unit i_fetch_unit (
        .clk(clk), .rst_n(rst_n), .br_sel(br_sel), .regs_equal(regs_equal),
        .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
        .instr(instr), .pc(pc)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic        sel;
        logic        eq;
        logic [31:0] pc_now;
        logic [31:0] pc_nxt;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{1'b0, 1'b0, 32'd0,  32'd4},
        '{1'b0, 1'b1, 32'd4,  32'd8},
        '{1'b1, 1'b0, 32'd8,  32'd12},
        '{1'b1, 1'b1, 32'd12, 32'd36},
        '{1'b1, 1'b1, 32'd36, 32'd24},
        '{1'b1, 1'b1, 32'd24, 32'd36},
        '{1'b1, 1'b1, 32'd36, 32'd24},
        '{1'b0, 1'b1, 32'd24, 32'd28},
        '{1'b1, 1'b1, 32'd28, 32'd32},
        '{1'b1, 1'b0, 32'd32, 32'd36},
        '{1'b0, 1'b0, 32'd36, 32'd40},
        '{1'b1, 1'b1, 32'd40, 32'hFFFE_002C},
        '{1'b0, 1'b0, 32'hFFFE_002C, 32'hFFFE_0030}
    };

    function automatic logic [15:0] imm_of(int k);
        case (k)
            3:       return 16'd5;
            6:       return 16'd2;
            7:       return 16'd0;
            9:       return 16'hFFFC;
            10:      return 16'h8000;
            default: return 16'(k * 3);
        endcase
    endfunction

    function automatic logic [31:0] word_of(int k);
        return {16'hC000 | 16'(k), imm_of(k)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // Fill the store while held in reset (R8: writes accepted in reset)
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            imem_we = 1'b1; imem_waddr = IW'(k); imem_wdata = word_of(k);
        end
        @(negedge clk);
        imem_we = 1'b0;
        check("R1 reset pc", pc, 32'd0);
        check("R8 preload visible", instr, word_of(0));
        rst_n = 1'b1;

        // Vector walk
        for (int i = 0; i < 13; i++) begin
            string tag;
            int idx;
            idx = int'((VECS[i].pc_now >> 2) & 32'(DEPTH - 1));
            if (!VECS[i].sel)      tag = "R3";
            else if (!VECS[i].eq)  tag = "R4";
            else if (imm_of(idx)[15]) tag = "R6";
            else                   tag = "R5";
            check("R7 pc now", pc, VECS[i].pc_now);
            check(VECS[i].pc_now >= 32'(4 * DEPTH) ? "R9 wrapped fetch" : "R2 fetch",
                  instr, word_of(idx));
            br_sel = VECS[i].sel; regs_equal = VECS[i].eq;
            @(posedge clk);
            @(negedge clk);
            check(tag, pc, VECS[i].pc_nxt);
            check("R7 align", {30'd0, pc[1:0]}, 32'd0);
        end

        // R1: synchronous reset, ignores branch inputs
        br_sel = 1'b1; regs_equal = 1'b1; rst_n = 1'b0;
        #5;
        check("R1 no async clear", pc, 32'hFFFE_0030);
        @(posedge clk); @(negedge clk);
        check("R1 cleared at edge", pc, 32'd0);

        // R8: write timing while in reset
        imem_we = 1'b1; imem_waddr = '0; imem_wdata = 32'h1234_5678;
        #5;
        check("R8 not before edge", instr, word_of(0));
        @(posedge clk); @(negedge clk);
        imem_we = 1'b0;
        check("R8 after edge", instr, 32'h1234_5678);
        check("R1 held in reset", pc, 32'd0);

        // Release and take a branch with the new word's offset (16'h5678 -> +0x159E0)
        rst_n = 1'b1; br_sel = 1'b1; regs_equal = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R5 branch from rewritten word", pc, 32'h0001_59E4);
        check("R9 wrapped fetch", instr, word_of(int'((32'h0001_59E4 >> 2) & 32'(DEPTH - 1))));
        br_sel = 1'b0;

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule